// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets synchronous logic read and write an external 8-bit-wide asynchronous static RAM of up to 8192 words. A user issues a single request made of a write flag, an address and, for writes, a data byte. The controller then runs the memory strobes through a fixed sequence built from registered outputs. Reads return their byte together with a one-cycle valid pulse. A ready flag tells the user when the next request can be accepted.

Every strobe width follows the memory's nanosecond timing limits. The controller converts each limit into clock cycles by ceiling division, using the clock period given as a parameter, and never uses fewer than one cycle. A second parameter chooses between the fast and the slow speed grade of the memory.

Writes keep both chip enables active and lower write enable on the same edge that presents the address. The write is ended by the rising edge of write enable. Address, data and chip enables are held at least one cycle beyond that edge. The shared data bus is driven only inside a write. When a write follows a read too closely, the controller waits until the memory has had time to release the bus.

Top module: `async_sram_ctl`

## Requirements
- R1: After reset, ready is 1, rvalid is 0, both chip enables are inactive (mem_sel_n=1, mem_sel=0), mem_oe_n=1, mem_we_n=1 and mem_dq_oe=0.
- R2: During a read the controller holds mem_sel_n=0, mem_sel=1, mem_oe_n=0 and mem_we_n=1, and mem_dq_oe stays 0 while mem_oe_n is 0.
- R3: A read keeps output enable low for N_RD cycles, where N_RD is the largest of the converted read-cycle, address-access and output-enable-access times. The byte on mem_dq_in at the end of the last of those cycles appears on rdata. rvalid is 1 for exactly one cycle, N_RD+1 cycles after the cycle in which the request was presented.
- R4: A write holds mem_we_n=0 for exactly N_WE cycles, where N_WE is the largest of the converted write-pulse, address-setup-to-write-end and data-setup times. Both chip enables stay active, mem_dq_oe stays 1 and mem_oe_n stays 1 throughout.
- R5: A write ends on the rising edge of mem_we_n. At that edge, address, data, chip enables and mem_dq_oe are unchanged. Chip select lasts at least the converted write-cycle time.
- R6: The address stays stable for as long as the chip enables are active. On a write with no turnaround pending, write enable falls on the same edge that presents the address.
- R7: The controller never drives the data bus while the memory could be driving it, that is, while selected with mem_oe_n=0 and mem_we_n=1.
- R8: mem_dq_oe rises no earlier than N_TA cycles after mem_oe_n last rose, where N_TA is the converted output-disable time. A write issued with no recent read starts driving on the acceptance edge.
- R9: A request is accepted only while ready is 1. ready falls on acceptance and is 1 again in the cycle in which the access completes (the rvalid cycle for reads).
- R10: Timing limits are converted as ceil(ns / CLK_PERIOD_NS) with a minimum of 1. With the fast grade at 10 ns this gives N_WE=4, N_RD=6, N_TA=3, and write chip select lasts 5 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, taken while ready is 1 |
| req_wr | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 13 | Word address of the request |
| req_wdata | input | 8 | Byte to write |
| ready | output | 1 | Controller idle and able to accept |
| rvalid | output | 1 | One-cycle pulse marking rdata valid |
| rdata | output | 8 | Byte returned by a read |
| mem_addr | output | 13 | Memory address bus |
| mem_sel_n | output | 1 | Active-low chip enable |
| mem_sel | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data to the bus during writes |
| mem_dq_oe | output | 1 | Enables the data-bus output driver |
| mem_dq_in | input | 8 | Data sampled from the bus |

## Verification
The hardest situation to reach is a write that must wait for the bus: it arises only when a write request lands within N_TA cycles of a read finishing. The bench reaches it by issuing a write at the very next opportunity after a read returns, and compares this with a write that follows an idle gap. The bench runs a memory model that returns a garbage byte until the access and output-enable delays have elapsed in cycles, so early capture shows up as wrong data. The design is instantiated with a 10-bit address, so every word can be written and then read back in one sweep.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WRITE,
        ST_WREC,
        ST_READ
    } ctl_state_e;

    // Memory timing limits in nanoseconds
    typedef struct packed {
        int unsigned t_wcyc;
        int unsigned t_wpulse;
        int unsigned t_dsetup;
        int unsigned t_asetup;
        int unsigned t_rcyc;
        int unsigned t_aacc;
        int unsigned t_oeacc;
        int unsigned t_oehz;
    } sram_timing_t;

    // Pin levels for one cycle, active-high view
    typedef struct packed {
        logic sel;
        logic oe;
        logic we;
        logic drive;
    } bus_ctl_t;

    function automatic sram_timing_t grade_timing(input int unsigned grade);
        sram_timing_t t;
        if (grade == 0) begin
            t.t_wcyc   = 50;
            t.t_wpulse = 25;
            t.t_dsetup = 25;
            t.t_asetup = 40;
            t.t_rcyc   = 55;
            t.t_aacc   = 55;
            t.t_oeacc  = 35;
            t.t_oehz   = 25;
        end else begin
            t.t_wcyc   = 70;
            t.t_wpulse = 40;
            t.t_dsetup = 35;
            t.t_asetup = 55;
            t.t_rcyc   = 70;
            t.t_aacc   = 70;
            t.t_oeacc  = 35;
            t.t_oehz   = 30;
        end
        return t;
    endfunction

    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic bus_ctl_t decode_bus(input ctl_state_e st);
        bus_ctl_t c;
        c.sel   = (st == ST_WRITE) || (st == ST_WREC) || (st == ST_READ);
        c.oe    = (st == ST_READ);
        c.we    = (st == ST_WRITE);
        c.drive = (st == ST_WRITE) || (st == ST_WREC);
        return c;
    endfunction

endpackage

// File: rtl/sram_turn_guard.sv
module sram_turn_guard #(
    parameter int unsigned N_TA = 3,
    parameter int unsigned CW   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_done,
    output logic bus_clear
);
    logic [CW-1:0] hz_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hz_q <= '0;
        end else if (rd_done) begin
            hz_q <= CW'(N_TA);
        end else if (hz_q != '0) begin
            hz_q <= hz_q - 1'b1;
        end
    end

    // Driving may start on the edge where at most one wait cycle remains
    assign bus_clear = (hz_q <= CW'(1));
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctl_pkg::*;
#(
    parameter int unsigned N_WE   = 4,
    parameter int unsigned N_WREC = 1,
    parameter int unsigned N_RD   = 6,
    parameter int unsigned CW     = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       req_wr,
    input  logic       bus_clear,
    output logic       accept,
    output ctl_state_e nxt_state,
    output logic       capture,
    output logic       rd_done
);
    ctl_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    always_comb begin
        nxt_state = state_q;
        cnt_d     = cnt_q;
        accept    = 1'b0;
        capture   = 1'b0;
        rd_done   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    if (req_wr) begin
                        if (bus_clear) begin
                            nxt_state = ST_WRITE;
                            cnt_d     = CW'(N_WE - 1);
                        end else begin
                            nxt_state = ST_TURN;
                        end
                    end else begin
                        nxt_state = ST_READ;
                        cnt_d     = CW'(N_RD - 1);
                    end
                end
            end
            ST_TURN: begin
                if (bus_clear) begin
                    nxt_state = ST_WRITE;
                    cnt_d     = CW'(N_WE - 1);
                end
            end
            ST_WRITE: begin
                if (cnt_q == '0) begin
                    nxt_state = ST_WREC;
                    cnt_d     = CW'(N_WREC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_WREC: begin
                if (cnt_q == '0) begin
                    nxt_state = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_READ: begin
                if (cnt_q == '0) begin
                    nxt_state = ST_IDLE;
                    capture   = 1'b1;
                    rd_done   = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= nxt_state;
            cnt_q   <= cnt_d;
        end
    end
endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
    import sram_ctl_pkg::*;
#(
    parameter int unsigned AW = 13,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  ctl_state_e    nxt_state,
    input  logic          capture,
    input  logic [DW-1:0] mem_dq_in,
    output logic          ready,
    output logic          rvalid,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_sel_n,
    output logic          mem_sel,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe
);
    bus_ctl_t nxt_bus;

    always_comb nxt_bus = decode_bus(nxt_state);

    always_ff @(posedge clk) begin
        if (rst) begin
            ready      <= 1'b1;
            rvalid     <= 1'b0;
            rdata      <= '0;
            mem_addr   <= '0;
            mem_dq_out <= '0;
            mem_sel_n  <= 1'b1;
            mem_sel    <= 1'b0;
            mem_oe_n   <= 1'b1;
            mem_we_n   <= 1'b1;
            mem_dq_oe  <= 1'b0;
        end else begin
            ready     <= (nxt_state == ST_IDLE);
            rvalid    <= capture;
            mem_sel_n <= ~nxt_bus.sel;
            mem_sel   <= nxt_bus.sel;
            mem_oe_n  <= ~nxt_bus.oe;
            mem_we_n  <= ~nxt_bus.we;
            mem_dq_oe <= nxt_bus.drive;
            if (capture) begin
                rdata <= mem_dq_in;
            end
            if (accept) begin
                mem_addr   <= req_addr;
                mem_dq_out <= req_wdata;
            end
        end
    end
endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned SPEED_GRADE   = 0,
    parameter int unsigned AW            = 13,
    parameter int unsigned DW            = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ready,
    output logic          rvalid,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_sel_n,
    output logic          mem_sel,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam sram_timing_t TM = grade_timing(SPEED_GRADE);
    localparam int unsigned C_WCYC = ns2cyc(TM.t_wcyc, CLK_PERIOD_NS);
    localparam int unsigned N_WE   = umax(umax(ns2cyc(TM.t_wpulse, CLK_PERIOD_NS),
                                               ns2cyc(TM.t_asetup, CLK_PERIOD_NS)),
                                          ns2cyc(TM.t_dsetup, CLK_PERIOD_NS));
    localparam int unsigned N_WREC = (C_WCYC > N_WE + 1) ? (C_WCYC - N_WE) : 1;
    localparam int unsigned N_RD   = umax(umax(ns2cyc(TM.t_rcyc, CLK_PERIOD_NS),
                                               ns2cyc(TM.t_aacc, CLK_PERIOD_NS)),
                                          ns2cyc(TM.t_oeacc, CLK_PERIOD_NS));
    localparam int unsigned N_TA   = ns2cyc(TM.t_oehz, CLK_PERIOD_NS);
    localparam int unsigned N_MAX  = umax(umax(N_WE, N_WREC), umax(N_RD, N_TA));
    localparam int unsigned CW     = $clog2(N_MAX + 1);

    logic       accept;
    logic       capture;
    logic       rd_done;
    logic       bus_clear;
    ctl_state_e nxt_state;

    sram_turn_guard #(
        .N_TA (N_TA),
        .CW   (CW)
    ) u_guard (
        .clk       (clk),
        .rst       (rst),
        .rd_done   (rd_done),
        .bus_clear (bus_clear)
    );

    sram_seq_fsm #(
        .N_WE   (N_WE),
        .N_WREC (N_WREC),
        .N_RD   (N_RD),
        .CW     (CW)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .req_wr    (req_wr),
        .bus_clear (bus_clear),
        .accept    (accept),
        .nxt_state (nxt_state),
        .capture   (capture),
        .rd_done   (rd_done)
    );

    sram_pin_regs #(
        .AW (AW),
        .DW (DW)
    ) u_pins (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .nxt_state  (nxt_state),
        .capture    (capture),
        .mem_dq_in  (mem_dq_in),
        .ready      (ready),
        .rvalid     (rvalid),
        .rdata      (rdata),
        .mem_addr   (mem_addr),
        .mem_sel_n  (mem_sel_n),
        .mem_sel    (mem_sel),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe)
    );
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int unsigned AW = 13,
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          ready,
    input logic          rvalid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_sel_n,
    input logic          mem_sel,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [DW-1:0] mem_dq_out,
    input logic          mem_dq_oe
);
    // R7 / R2: no driver overlap with memory output enable
    a_r7_no_bus_fight: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe);

    // R2: read strobes never coincide with write strobe
    a_r2_oe_we_apart: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_we_n && !mem_sel_n && mem_sel));

    // R4: write enable only inside a selected, driven window
    a_r4_we_window: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_sel_n && mem_sel && mem_dq_oe && mem_oe_n));

    // R5: address, data and select hold across the terminating edge
    a_r5_hold_at_we_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (!mem_sel_n && mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out)));

    // R6: address frozen while selected
    a_r6_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

    // R3: valid strobe lasts one cycle
    a_r3_rvalid_pulse: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

    // R9: controller is not ready while the memory is selected
    a_r9_busy_when_selected: assert property (@(posedge clk) disable iff (rst)
        !mem_sel_n |-> !ready);
endmodule

bind async_sram_ctl sram_ctl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ready      (ready),
    .rvalid     (rvalid),
    .mem_addr   (mem_addr),
    .mem_sel_n  (mem_sel_n),
    .mem_sel    (mem_sel),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/test_async_sram_ctl.sv
module test_async_sram_ctl;
    localparam int CLK_NS = 10;
    localparam int TAW    = 10;
    localparam int WORDS  = 1 << TAW;

    function automatic int cdiv(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    function automatic logic [7:0] pat(input int a, input int salt);
        return 8'((a * 37 + (a >> 3) + salt) & 255);
    endfunction

    // Fast grade: write 50/25/25(data)/40(addr), read 55/55/35, release 25
    localparam int E_WE  = mx(mx(cdiv(25), cdiv(40)), cdiv(25));
    localparam int E_WC  = cdiv(50);
    localparam int E_RD  = mx(mx(cdiv(55), cdiv(55)), cdiv(35));
    localparam int E_TA  = cdiv(25);
    localparam int E_AA  = cdiv(55);
    localparam int E_DOE = cdiv(35);
    localparam int E_SD  = cdiv(25);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           req = 1'b0;
    logic           req_wr = 1'b0;
    logic [TAW-1:0] req_addr = '0;
    logic [7:0]     req_wdata = '0;
    logic           ready, rvalid;
    logic [7:0]     rdata;
    logic [TAW-1:0] mem_addr;
    logic           mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]     mem_dq_out;
    logic [7:0]     mem_dq_in = 8'h5A;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    logic [7:0] mem [0:WORDS-1];

    async_sram_ctl #(
        .CLK_PERIOD_NS (CLK_NS),
        .SPEED_GRADE   (0),
        .AW            (TAW),
        .DW            (8)
    ) i_async_sram_ctl (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .req_wr     (req_wr),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .ready      (ready),
        .rvalid     (rvalid),
        .rdata      (rdata),
        .mem_addr   (mem_addr),
        .mem_sel_n  (mem_sel_n),
        .mem_sel    (mem_sel),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );

    always #(CLK_NS / 2) clk = ~clk;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Memory model and pin monitor, sampled at falling edges
    logic [TAW-1:0] p_addr = '0;
    logic [7:0]     p_data = '0;
    logic           p_we_n = 1'b1, p_sel = 1'b0, p_oe_n = 1'b1, p_dq_oe = 1'b0;
    int addr_age = 0, data_age = 0, oe_low = 0, oe_high = 1000, we_low = 0, sel_cnt = 0;
    bit wrote = 0;

    always @(negedge clk) begin
        logic sel;
        logic mdrv;
        if (!rst) begin
            sel  = !mem_sel_n && mem_sel;
            mdrv = sel && !mem_oe_n && mem_we_n;
            chk(!(mdrv && mem_dq_oe), "R7 bus fight", int'(mem_dq_oe), 0);
            if (sel && p_sel)
                chk(mem_addr == p_addr, "R6 addr stable", int'(mem_addr), int'(p_addr));
            addr_age = (mem_addr != p_addr) ? 1 : addr_age + 1;
            data_age = (mem_dq_out != p_data) ? 1 : data_age + 1;
            oe_low   = !mem_oe_n ? oe_low + 1 : 0;
            oe_high  = mem_oe_n ? ((oe_high < 1000) ? oe_high + 1 : 1000) : 0;
            if (!mem_oe_n)
                chk(mem_we_n && sel && !mem_dq_oe, "R2 read pins", int'(mem_we_n), 1);
            if (!mem_we_n)
                chk(sel && mem_dq_oe && mem_oe_n, "R4 write window", int'(mem_dq_oe), 1);
            if (mem_dq_oe && !p_dq_oe)
                chk(oe_high >= E_TA + 1, "R8 turnaround", oe_high - 1, E_TA);
            if (!p_we_n && mem_we_n) begin
                chk(we_low == E_WE, "R4 we width", we_low, E_WE);
                chk(sel && mem_dq_oe, "R5 held at we rise", int'(mem_dq_oe), 1);
                chk(data_age > E_SD, "R5 data setup", data_age, E_SD + 1);
                mem[mem_addr] = mem_dq_out;
                wrote = 1;
            end
            we_low = !mem_we_n ? we_low + 1 : 0;
            if (p_sel && !sel && wrote) begin
                chk(sel_cnt >= E_WC, "R10 write cycle", sel_cnt, E_WC);
                wrote = 0;
            end
            sel_cnt = sel ? sel_cnt + 1 : 0;
            if (mdrv && oe_low >= E_DOE && addr_age >= E_AA)
                mem_dq_in <= mem[mem_addr];
            else
                mem_dq_in <= 8'h5A;
            p_addr = mem_addr; p_data = mem_dq_out; p_we_n = mem_we_n;
            p_sel = sel; p_oe_n = mem_oe_n; p_dq_oe = mem_dq_oe;
        end
    end

    // Called at a falling edge; returns at a falling edge with ready high
    task automatic do_write(input int a, input logic [7:0] d, input bit nowait);
        while (!ready) @(negedge clk);
        req = 1; req_wr = 1; req_addr = TAW'(a); req_wdata = d;
        @(negedge clk);
        req = 0;
        chk(!ready, "R9 ready falls", int'(ready), 0);
        if (nowait) begin
            chk(mem_dq_oe && !mem_we_n, "R8 no wait when idle", int'(mem_dq_oe), 1);
            chk(mem_addr == TAW'(a), "R6 addr with we", int'(mem_addr), a);
        end
        while (!ready) @(negedge clk);
    endtask

    task automatic do_read(input int a, input logic [7:0] exp);
        int n;
        while (!ready) @(negedge clk);
        req = 1; req_wr = 0; req_addr = TAW'(a);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) req = 0;
        end while (!rvalid && n < 50);
        chk(n == E_RD + 1, "R3 read latency", n, E_RD + 1);
        chk(rdata == exp, "R3 read data", int'(rdata), int'(exp));
        chk(ready, "R9 ready with rvalid", int'(ready), 1);
        @(negedge clk);
        chk(!rvalid, "R3 rvalid one cycle", int'(rvalid), 0);
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset levels
        chk(ready == 1, "R1 ready", int'(ready), 1);
        chk(rvalid == 0, "R1 rvalid", int'(rvalid), 0);
        chk(mem_sel_n == 1 && mem_sel == 0, "R1 enables", int'(mem_sel), 0);
        chk(mem_oe_n == 1 && mem_we_n == 1, "R1 strobes", int'(mem_we_n), 1);
        chk(mem_dq_oe == 0, "R1 bus idle", int'(mem_dq_oe), 0);
        rst = 0;
        @(negedge clk);
        chk(E_WE == 4 && E_RD == 6 && E_TA == 3, "R10 conversion", E_WE * 100 + E_RD * 10 + E_TA, 463);
        // Full write sweep then full read-back sweep
        for (int a = 0; a < WORDS; a++) do_write(a, pat(a, 0), a == 0);
        for (int a = 0; a < WORDS; a++) do_read(a, pat(a, 0));
        // Write right after a read: turnaround required
        for (int k = 0; k < 16; k++) begin
            do_read(k * 7, pat(k * 7, 0));
            do_write(k * 7, pat(k, 99), 0);
            do_read(k * 7, pat(k, 99));
        end
        // Write after an idle gap: no wait
        repeat (E_TA + 2) @(negedge clk);
        do_write(5, 8'hC3, 1);
        do_read(5, 8'hC3);
        // Two back-to-back reads of the same word
        do_read(5, 8'hC3);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule